// File: doc/BRIEF.md
# Transhybrid Echo Balance Filter

This block removes the part of the receive-direction signal that leaks back into the transmit direction through an imperfect two-to-four-wire hybrid. It takes in a receive sample and a transmit sample together on one strobe, which fires once per 16 kHz sample period. It runs the receive sample through a programmable echo model. The model's estimate is subtracted from the transmit sample, and the clean transmit sample leaves on the next clock.

The echo model has two stages. The first is a one-pole recursive stage with a feedforward gain and a feedback gain. The second is an eight-tap transversal stage that takes in the recursive stage's output. All ten coefficients are signed Q1.14 words, loaded through a simple address/data/write-enable port. Writes land in a staging bank. The whole set is copied into the working bank on a sample strobe, so a filter pass never sees a coefficient set that is only partly written.

Top module: `echo_balance_filter`

## Requirements
- R1: Each strobe on `smp_stb` produces exactly one result. `clean_vld` is high for the single cycle after the strobe edge, and `tx_clean` holds the new value from then on. With no strobe, `clean_vld` stays low and `tx_clean` keeps its value.
- R2: The recursive stage output is y = clip16((B*rx + A*s) >>> 14). B is the feedforward coefficient, A is the feedback coefficient, s is the previous y (zero after reset), and >>> is an arithmetic shift that rounds toward minus infinity.
- R3: The echo estimate is e = (sum over k=0..7 of H[k]*y[n-k]) >>> 14. Here y[n] is the recursive output of the current strobe and y[n-k] is its value k strobes earlier (zero before reset ended). The sum is kept at least 36 bits wide.
- R4: The result is tx_clean = clip16(tx - e), computed on the same strobe that supplied tx.
- R5: The result saturates: any value above 32767 becomes 32767, and any value below -32768 becomes -32768. No value wraps.
- R6: The recursive output y is itself clipped to the 16-bit range before it is stored as state and before it enters the transversal stage.
- R7: Coefficient addresses are: 0 = B, 1 = A, 2+k = H[k] for k=0..7, with data in Q1.14 two's complement. A write changes only the staging bank. The working bank is loaded from the staging bank on each strobe, after that strobe's pass. A write made before strobe n therefore first affects the result of strobe n+1.
- R8: Writes to addresses 10 to 15 change nothing.
- R9: Synchronous reset clears the recursive state, all transversal history, both coefficient banks, `tx_clean` and `clean_vld`.
- R10: With every coefficient zero, `tx_clean` equals the transmit sample exactly.
- R11: Filter state and the working coefficient bank change only on a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 1 | One-cycle sample strobe, 16 kHz rate |
| rx_smp | input | 16 | Receive-direction sample, signed |
| tx_smp | input | 16 | Transmit-direction sample, signed |
| cfg_we | input | 1 | Coefficient write enable |
| cfg_addr | input | 4 | Coefficient address |
| cfg_data | input | 16 | Coefficient value, signed Q1.14 |
| tx_clean | output | 16 | Transmit sample minus echo estimate, signed |
| clean_vld | output | 1 | Result valid, one cycle per strobe |

## Verification
All-zero coefficients show a pure pass-through. A unit feedforward path with only the first tap separates the subtraction from any delay. An impulse through distinct tap weights shows whether each history slot is weighted and ordered correctly. A half-gain feedback loop exposes errors in the recursive state and its rounding. Full-scale samples of opposite sign drive the output and the recursive stage into both clip limits, where a wrapping design gives the opposite sign. Coefficient writes placed between strobes, and writes to unused addresses, show whether the staging defers a change by exactly one strobe and whether stray writes are ignored. A mid-run reset shows whether all history is cleared.

// File: rtl/ebf_pkg.sv
package ebf_pkg;
  localparam int unsigned DEF_DATA_W = 16;
  localparam int unsigned DEF_COEF_W = 16;
  localparam int unsigned DEF_FRAC   = 14;
  localparam int unsigned DEF_TAPS   = 8;
  localparam int unsigned DEF_ACC_W  = 36;
  localparam int unsigned DEF_ADDR_W = 4;

  // coefficient address map
  localparam int unsigned ADDR_FF   = 0;
  localparam int unsigned ADDR_FB   = 1;
  localparam int unsigned ADDR_FIR0 = 2;
endpackage

// File: rtl/ebf_coef_bank.sv
module ebf_coef_bank #(
  parameter int unsigned COEF_W = ebf_pkg::DEF_COEF_W,
  parameter int unsigned TAPS   = ebf_pkg::DEF_TAPS,
  parameter int unsigned ADDR_W = ebf_pkg::DEF_ADDR_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_we,
  input  logic [ADDR_W-1:0]        cfg_addr,
  input  logic signed [COEF_W-1:0] cfg_data,
  input  logic                     swap,
  output logic signed [COEF_W-1:0] ff_coef,
  output logic signed [COEF_W-1:0] fb_coef,
  output logic signed [COEF_W-1:0] fir_coef [TAPS],
  output logic                     wr_hit
);
  localparam int unsigned NREG = TAPS + 2;

  logic signed [COEF_W-1:0] staged [NREG];
  logic signed [COEF_W-1:0] active [NREG];

  // a write counts only inside the mapped range
  assign wr_hit = cfg_we && (32'(cfg_addr) < NREG);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) begin
        staged[i] <= '0;
        active[i] <= '0;
      end
    end else begin
      if (wr_hit) staged[cfg_addr] <= cfg_data;
      if (swap) begin
        for (int i = 0; i < NREG; i++) active[i] <= staged[i];
      end
    end
  end

  assign ff_coef = active[ebf_pkg::ADDR_FF];
  assign fb_coef = active[ebf_pkg::ADDR_FB];

  for (genvar k = 0; k < TAPS; k++) begin : g_fir_out
    assign fir_coef[k] = active[ebf_pkg::ADDR_FIR0 + k];
  end
endmodule

// File: rtl/ebf_iir_stage.sv
module ebf_iir_stage #(
  parameter int unsigned DATA_W = ebf_pkg::DEF_DATA_W,
  parameter int unsigned COEF_W = ebf_pkg::DEF_COEF_W,
  parameter int unsigned FRAC   = ebf_pkg::DEF_FRAC
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     step,
  input  logic signed [DATA_W-1:0] x_in,
  input  logic signed [COEF_W-1:0] ff_coef,
  input  logic signed [COEF_W-1:0] fb_coef,
  output logic signed [DATA_W-1:0] y_now,
  output logic signed [DATA_W-1:0] state,
  output logic                     clip_hit
);
  localparam int unsigned SUM_W = DATA_W + COEF_W + 1;
  localparam logic signed [SUM_W-1:0] MAXV = SUM_W'((64'sd1 <<< (DATA_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] MINV = -MAXV - 1;

  function automatic logic signed [DATA_W-1:0] clip(input logic signed [SUM_W-1:0] v);
    if (v > MAXV) return MAXV[DATA_W-1:0];
    if (v < MINV) return MINV[DATA_W-1:0];
    return v[DATA_W-1:0];
  endfunction

  function automatic logic signed [SUM_W-1:0] mac2(
    input logic signed [DATA_W-1:0] xa, input logic signed [COEF_W-1:0] ca,
    input logic signed [DATA_W-1:0] xb, input logic signed [COEF_W-1:0] cb);
    logic signed [SUM_W-1:0] s;
    s = SUM_W'(xa) * SUM_W'(ca) + SUM_W'(xb) * SUM_W'(cb);
    return s >>> FRAC;
  endfunction

  logic signed [SUM_W-1:0] scaled;

  assign scaled   = mac2(x_in, ff_coef, state, fb_coef);
  assign clip_hit = (scaled > MAXV) || (scaled < MINV);
  assign y_now    = clip(scaled);

  always_ff @(posedge clk) begin
    if (rst)       state <= '0;
    else if (step) state <= y_now;
  end
endmodule

// File: rtl/ebf_fir_stage.sv
module ebf_fir_stage #(
  parameter int unsigned DATA_W = ebf_pkg::DEF_DATA_W,
  parameter int unsigned COEF_W = ebf_pkg::DEF_COEF_W,
  parameter int unsigned TAPS   = ebf_pkg::DEF_TAPS,
  parameter int unsigned ACC_W  = ebf_pkg::DEF_ACC_W,
  parameter int unsigned FRAC   = ebf_pkg::DEF_FRAC
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     step,
  input  logic signed [DATA_W-1:0] din,
  input  logic signed [COEF_W-1:0] coef [TAPS],
  output logic signed [ACC_W-1:0]  est,
  output logic signed [DATA_W-1:0] hist_head
);
  localparam int unsigned HIST = TAPS - 1;

  logic signed [DATA_W-1:0] hist [HIST];
  logic signed [DATA_W-1:0] tap  [TAPS];
  logic signed [ACC_W-1:0]  prod [TAPS];
  logic signed [ACC_W-1:0]  acc;

  function automatic logic signed [ACC_W-1:0] mul(
    input logic signed [DATA_W-1:0] d, input logic signed [COEF_W-1:0] c);
    return ACC_W'(d) * ACC_W'(c);
  endfunction

  assign tap[0] = din;
  for (genvar k = 1; k < TAPS; k++) begin : g_tap
    assign tap[k] = hist[k-1];
  end

  for (genvar k = 0; k < TAPS; k++) begin : g_prod
    assign prod[k] = mul(tap[k], coef[k]);
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < TAPS; k++) acc = acc + prod[k];
  end

  assign est       = acc >>> FRAC;
  assign hist_head = hist[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < HIST; k++) hist[k] <= '0;
    end else if (step) begin
      hist[0] <= din;
      for (int k = 1; k < HIST; k++) hist[k] <= hist[k-1];
    end
  end
endmodule

// File: rtl/echo_balance_filter.sv
module echo_balance_filter #(
  parameter int unsigned DATA_W = ebf_pkg::DEF_DATA_W,
  parameter int unsigned COEF_W = ebf_pkg::DEF_COEF_W,
  parameter int unsigned FRAC   = ebf_pkg::DEF_FRAC,
  parameter int unsigned TAPS   = ebf_pkg::DEF_TAPS,
  parameter int unsigned ACC_W  = ebf_pkg::DEF_ACC_W,
  parameter int unsigned ADDR_W = ebf_pkg::DEF_ADDR_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     smp_stb,
  input  logic signed [DATA_W-1:0] rx_smp,
  input  logic signed [DATA_W-1:0] tx_smp,
  input  logic                     cfg_we,
  input  logic [ADDR_W-1:0]        cfg_addr,
  input  logic signed [COEF_W-1:0] cfg_data,
  output logic signed [DATA_W-1:0] tx_clean,
  output logic                     clean_vld
);
  localparam logic signed [ACC_W-1:0] OUT_MAX = ACC_W'((64'sd1 <<< (DATA_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] OUT_MIN = -OUT_MAX - 1;

  logic signed [COEF_W-1:0] ff_act, fb_act;
  logic signed [COEF_W-1:0] fir_act [TAPS];
  logic                     cfg_hit;
  logic signed [DATA_W-1:0] iir_y, iir_state, hist_head;
  logic                     iir_clip;
  logic signed [ACC_W-1:0]  echo_est, diff;
  logic                     out_clip_hi, out_clip_lo;
  logic signed [DATA_W-1:0] diff_clipped;

  ebf_coef_bank #(.COEF_W(COEF_W), .TAPS(TAPS), .ADDR_W(ADDR_W)) u_bank (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .swap(smp_stb), .ff_coef(ff_act),
    .fb_coef(fb_act), .fir_coef(fir_act), .wr_hit(cfg_hit)
  );

  ebf_iir_stage #(.DATA_W(DATA_W), .COEF_W(COEF_W), .FRAC(FRAC)) u_iir (
    .clk(clk), .rst(rst), .step(smp_stb), .x_in(rx_smp),
    .ff_coef(ff_act), .fb_coef(fb_act), .y_now(iir_y),
    .state(iir_state), .clip_hit(iir_clip)
  );

  ebf_fir_stage #(.DATA_W(DATA_W), .COEF_W(COEF_W), .TAPS(TAPS),
                  .ACC_W(ACC_W), .FRAC(FRAC)) u_fir (
    .clk(clk), .rst(rst), .step(smp_stb), .din(iir_y),
    .coef(fir_act), .est(echo_est), .hist_head(hist_head)
  );

  function automatic logic signed [DATA_W-1:0] clip_out(input logic signed [ACC_W-1:0] v);
    if (v > OUT_MAX) return OUT_MAX[DATA_W-1:0];
    if (v < OUT_MIN) return OUT_MIN[DATA_W-1:0];
    return v[DATA_W-1:0];
  endfunction

  assign diff         = ACC_W'(tx_smp) - echo_est;
  assign out_clip_hi  = diff > OUT_MAX;
  assign out_clip_lo  = diff < OUT_MIN;
  assign diff_clipped = clip_out(diff);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_clean  <= '0;
      clean_vld <= 1'b0;
    end else begin
      clean_vld <= smp_stb;
      if (smp_stb) tx_clean <= diff_clipped;
    end
  end
endmodule

// File: rtl/ebf_checker.sv
module ebf_checker #(
  parameter int unsigned DATA_W = ebf_pkg::DEF_DATA_W,
  parameter int unsigned COEF_W = ebf_pkg::DEF_COEF_W
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     smp_stb,
  input logic                     clean_vld,
  input logic signed [DATA_W-1:0] tx_clean,
  input logic                     out_clip_hi,
  input logic                     out_clip_lo,
  input logic signed [DATA_W-1:0] iir_state,
  input logic signed [DATA_W-1:0] hist_head,
  input logic signed [COEF_W-1:0] ff_act,
  input logic signed [COEF_W-1:0] fb_act
);
  localparam logic signed [DATA_W-1:0] TOP = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic signed [DATA_W-1:0] BOT = {1'b1, {(DATA_W-1){1'b0}}};

  assert_vld_after_stb_R1: assert property (@(posedge clk) disable iff (rst)
    smp_stb |=> clean_vld);
  assert_vld_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !smp_stb |=> !clean_vld);
  assert_out_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !smp_stb |=> $stable(tx_clean));
  assert_clip_top_R5: assert property (@(posedge clk) disable iff (rst)
    (smp_stb && out_clip_hi) |=> (tx_clean == TOP));
  assert_clip_bot_R5: assert property (@(posedge clk) disable iff (rst)
    (smp_stb && out_clip_lo) |=> (tx_clean == BOT));
  assert_state_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !smp_stb |=> ($stable(iir_state) && $stable(hist_head)));
  assert_coef_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !smp_stb |=> ($stable(ff_act) && $stable(fb_act)));
  assert_reset_clear_R9: assert property (@(posedge clk)
    rst |=> (tx_clean == '0 && !clean_vld && iir_state == '0 && ff_act == '0));
endmodule

bind echo_balance_filter ebf_checker #(.DATA_W(DATA_W), .COEF_W(COEF_W)) u_chk (
  .clk(clk), .rst(rst), .smp_stb(smp_stb), .clean_vld(clean_vld),
  .tx_clean(tx_clean), .out_clip_hi(out_clip_hi), .out_clip_lo(out_clip_lo),
  .iir_state(iir_state), .hist_head(hist_head), .ff_act(ff_act), .fb_act(fb_act)
);

// File: tb/sim_echo_balance_filter.sv
module sim_echo_balance_filter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_stb = 1'b0;
  logic signed [15:0] rx_smp = '0, tx_smp = '0, cfg_data = '0;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic signed [15:0] tx_clean;
  logic clean_vld;

  int n_chk = 0, n_bad = 0;

  // bench-side model state
  longint stg [10];
  longint act [10];
  longint st;
  longint past [7];

  always #5 clk = ~clk;

  echo_balance_filter u0 (
    .clk(clk), .rst(rst), .smp_stb(smp_stb), .rx_smp(rx_smp), .tx_smp(tx_smp),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .tx_clean(tx_clean), .clean_vld(clean_vld)
  );

  function automatic longint lim(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic check(string req, longint got, longint want);
    n_chk++;
    if (got != want) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, want);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 10; i++) begin stg[i] = 0; act[i] = 0; end
    for (int i = 0; i < 7; i++) past[i] = 0;
    st = 0;
  endtask

  // R2/R3/R4: expected result for one strobe, then advance model
  function automatic longint model_step(longint rx, longint tx);
    longint y, sum, e, r;
    y = lim((act[0] * rx + act[1] * st) >>> 14);
    sum = act[2] * y;
    for (int k = 1; k < 8; k++) sum += act[2 + k] * past[k - 1];
    e = sum >>> 14;
    r = lim(tx - e);
    for (int k = 6; k > 0; k--) past[k] = past[k - 1];
    past[0] = y;
    st = y;
    for (int i = 0; i < 10; i++) act[i] = stg[i];
    return r;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    model_reset();
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'(a); cfg_data = 16'(d);
    if (a < 10) stg[a] = longint'(signed'(16'(d)));
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // drive one strobe and return the registered result
  task automatic strobe(int rx, int tx, string req, output longint got, output longint want);
    @(negedge clk);
    smp_stb = 1'b1; rx_smp = 16'(rx); tx_smp = 16'(tx);
    want = model_step(rx, tx);
    @(negedge clk);
    smp_stb = 1'b0;
    check({req, " valid"}, longint'(clean_vld), 1);
    got = longint'(tx_clean);
    check(req, got, want);
  endtask

  // commit staged coefficients with a zero-input strobe
  task automatic commit();
    longint g, w;
    strobe(0, 0, "R7 commit", g, w);
  endtask

  task automatic t_reset();
    check("R9 reset out", longint'(tx_clean), 0);
    check("R9 reset valid", longint'(clean_vld), 0);
  endtask

  task automatic t_passthrough();
    longint g, w;
    int vals [4] = '{1234, -32768, 32767, -7};
    foreach (vals[i]) begin
      strobe(5000, vals[i], "R10 passthrough", g, w);
      check("R10 equals tx", g, vals[i]);
    end
  endtask

  task automatic t_direct();
    longint g, w;
    wr(0, 16384); wr(2, 16384); commit();
    strobe(1000, 3000, "R4 direct", g, w);
    check("R4 tx minus rx", g, 2000);
    strobe(-2500, 100, "R2 direct", g, w);
    check("R2 unit gain", g, 2600);
  endtask

  task automatic t_feedback();
    longint g, w;
    wr(1, 8192); commit();
    strobe(1000, 0, "R2 impulse", g, w);
    check("R2 impulse value", g, -1000);
    strobe(0, 0, "R2 decay1", g, w);
    check("R2 decay half", g, -500);
    strobe(0, 0, "R2 decay2", g, w);
    strobe(-3, 0, "R2 floor", g, w);
  endtask

  task automatic t_taps();
    longint g, w;
    do_reset();
    wr(0, 16384);
    for (int k = 0; k < 8; k++) wr(2 + k, 1000 * (k + 1));
    commit();
    strobe(16384, 0, "R3 tap0", g, w);
    for (int k = 1; k < 9; k++) strobe(0, 0, $sformatf("R3 tap%0d", k), g, w);
    check("R3 tail empty", g, 0);
  endtask

  task automatic t_clip();
    longint g, w;
    do_reset();
    wr(0, 16384); wr(2, 16384); commit();
    strobe(-32768, 32767, "R5 high", g, w);
    check("R5 clip top", g, 32767);
    strobe(32767, -32768, "R5 low", g, w);
    check("R5 clip bottom", g, -32768);
    wr(0, 32767); commit();
    strobe(32767, 0, "R6 iir clip", g, w);
    check("R6 clipped y", g, -32767);
  endtask

  task automatic t_staging();
    longint g, w;
    do_reset();
    wr(0, 16384); wr(2, 16384); commit();
    wr(2, 8192);
    strobe(4000, 0, "R7 old set", g, w);
    check("R7 old still used", g, -4000);
    strobe(4000, 0, "R7 new set", g, w);
    check("R7 new used", g, -2000);
  endtask

  task automatic t_ignored();
    longint g, w;
    for (int a = 10; a < 16; a++) wr(a, 12345);
    commit();
    strobe(4000, 100, "R8 unmapped", g, w);
    check("R8 unchanged", g, -1900);
  endtask

  task automatic t_idle();
    longint hold;
    hold = longint'(tx_clean);
    repeat (5) @(negedge clk);
    check("R1 idle valid", longint'(clean_vld), 0);
    check("R11 idle hold", longint'(tx_clean), hold);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R1 watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_passthrough();
    t_direct();
    t_feedback();
    t_idle();
    t_taps();
    t_clip();
    t_staging();
    t_ignored();
    do_reset();
    t_reset();
    t_passthrough();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule